// File: doc/BRIEF.md
# Command Queue Pointer Tracker

This block keeps the pointer state of a single command queue that fetches work either from a power-of-two ring buffer or from a linear indirect buffer. For the ring it holds a base address, a read pointer and a write pointer. For the indirect buffer it holds its own base, read pointer and write pointer. A mode bit selects which of the two pairs is active. From this state the block forms the byte address of the next fetch and the byte address that the producer has written up to. It also raises a flag when the active pair shows no pending work.

A queue-mapping step loads the ring size field, the ring base, the starting read pointer and the mapping fields in one cycle. After that the fetch engine moves the active read pointer in several ways: it advances it by a dword count, overwrites it, or jumps it to the write pointer. The jump is used when a no-op packet carries the all-ones count. Doorbell writes always update the ring write pointer, even while the queue is fetching from the indirect buffer. The ring pointers count freely and are never wrapped. Only the address that leaves the block is reduced modulo the ring size.

Top module: `cmdq_ptr_tracker`

## Requirements
- R1: After reset the ring mode is selected, all bases and pointers are zero, `fetchAddr` and `wrAddr` are 0, `empty` is 1, `privileged` is 0 and `engineNum` is 0.
- R2: When `cfgLoad` is 1, the next cycle shows ring mode, both ring pointers equal to `cfgInitRptr`, both indirect pointers equal to 0, and the new ring base and size field. `cfgLoad` overrides every pointer, mode and doorbell operation requested in the same cycle.
- R3: The ring size in bytes is 4 << (`cfgRingLog` + 1), which is 2^(`cfgRingLog`+3). In ring mode `fetchAddr` = ring base + (ring read pointer mod size), and the sum wraps at the pointer width. If the size is 2^PTR_W or more, no modulo is applied. The stored read pointer keeps counting past the size.
- R4: In ring mode `wrAddr` = ring base + (ring write pointer mod ring size).
- R5: In indirect mode (`ibMode`=1), `fetchAddr` = indirect base + indirect read pointer and `wrAddr` = indirect base + indirect write pointer, with no modulo applied. `ibBaseLoad` loads the indirect base from `ibBaseIn` in any cycle.
- R6: `advValid` adds 4*`advDwords` bytes to the read pointer of the active mode. The read pointer of the other mode is unchanged.
- R7: `rptrSet` and `wptrSet` write `rptrVal` and `wptrVal` into the active mode's read and write pointers only. The other pair is unchanged.
- R8: `ffwd` copies the active mode's write pointer, as it stood before the edge, into that mode's read pointer in one cycle. For the read pointer the priority is `ffwd` first, then `rptrSet`, then `advValid`.
- R9: `dbValid` writes `dbWptr` into the ring write pointer in either mode. In ring mode a `wptrSet` in the same cycle takes priority over it. A doorbell applies alongside any read-pointer operation in the same cycle.
- R10: `empty` is 1 exactly when the active mode's read pointer equals its write pointer over the full pointer width, without any modulo.
- R11: On `cfgLoad`, `privileged` becomes 1 when `cfgQueueSel` is 0 and 0 otherwise, and `engineNum` becomes `cfgEngine` + 1.
- R12: `modeSet` loads `modeIbIn` into the mode bit (1 = indirect) from the next cycle. Operations in the same cycle act on the old mode. Both pairs keep their values across mode switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Map the queue: load size field, ring base, start pointer, mapping fields |
| cfgRingLog | input | LOG_W | Ring size field of the control word |
| cfgRingBase | input | PTR_W | Ring base byte address |
| cfgInitRptr | input | PTR_W | Starting ring read pointer, also the starting ring write pointer |
| cfgQueueSel | input | QSEL_W | Mapping queue-select field |
| cfgEngine | input | ENG_W | Mapping engine field |
| ibBaseLoad | input | 1 | Load the indirect-buffer base |
| ibBaseIn | input | PTR_W | Indirect-buffer base byte address |
| modeSet | input | 1 | Change fetch mode |
| modeIbIn | input | 1 | New mode, 1 = indirect, 0 = ring |
| advValid | input | 1 | Advance active read pointer |
| advDwords | input | CNT_W | Advance amount in dwords |
| rptrSet | input | 1 | Overwrite active read pointer |
| rptrVal | input | PTR_W | Value for `rptrSet` |
| wptrSet | input | 1 | Overwrite active write pointer |
| wptrVal | input | PTR_W | Value for `wptrSet` |
| dbValid | input | 1 | Doorbell write-pointer update |
| dbWptr | input | PTR_W | Doorbell write pointer for the ring |
| ffwd | input | 1 | Jump active read pointer to its write pointer |
| fetchAddr | output | PTR_W | Byte address of the next fetch |
| wrAddr | output | PTR_W | Byte address of the producer's write position |
| empty | output | 1 | Active read pointer equals active write pointer |
| ibMode | output | 1 | Current mode, 1 = indirect |
| privileged | output | 1 | Queue was mapped with queue-select 0 |
| engineNum | output | ENG_W+1 | Engine field + 1 |

## Verification
The bench builds the block with PTR_W=16, LOG_W=6, CNT_W=14, QSEL_W=2 and ENG_W=2. The 16-bit pointer width lets random advances of up to 0x3FFF dwords wrap the free-running pointers and the address sums. Any size field of 13 or more gives a ring of at least 2^16 bytes, so the saturated no-modulo case is reachable, along with every smaller ring size. The full 6-bit size field is still used, so the largest setting, 63, is covered.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  // Read-pointer operation chosen for one pointer pair in a cycle.
  typedef enum logic [1:0] {
    RP_HOLD = 2'd0,
    RP_ADV  = 2'd1,
    RP_SET  = 2'd2,
    RP_FFWD = 2'd3
  } rpOp_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic  cfgLoad;
    logic  ibBaseLoad;
    rpOp_e ringRp;
    rpOp_e ibRp;
    logic  ringWpSet;
    logic  ringWpDb;
    logic  ibWpSet;
  } strobe_t;

endpackage

// File: rtl/cmdq_size_mask.sv
// Turns the ring size field into the byte mask (size - 1).
// Size = 2^(field + 3); a size at or above 2^PTR_W saturates to all ones.
module cmdq_size_mask #(
  parameter int PTR_W = 64,
  parameter int LOG_W = 6
) (
  input  logic [LOG_W-1:0] logField,
  output logic [PTR_W-1:0] mask
);
  localparam int SH_W = LOG_W + 1;

  logic [SH_W-1:0] shAmt;
  assign shAmt = SH_W'(logField) + SH_W'(3);

  // Bit i of the mask is set while i lies below the size exponent.
  for (genvar i = 0; i < PTR_W; i++) begin : g_bit
    assign mask[i] = (int'(shAmt) > i);
  end

endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgLoad,
  input  logic    ibBaseLoad,
  input  logic    modeSet,
  input  logic    modeIbIn,
  input  logic    advValid,
  input  logic    rptrSet,
  input  logic    wptrSet,
  input  logic    dbValid,
  input  logic    ffwd,
  output strobe_t strb,
  output logic    modeIb
);

  rpOp_e activeOp;

  // Read-pointer priority: jump, then overwrite, then advance.
  always_comb begin
    if (ffwd)          activeOp = RP_FFWD;
    else if (rptrSet)  activeOp = RP_SET;
    else if (advValid) activeOp = RP_ADV;
    else               activeOp = RP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          modeIb <= 1'b0;
    else if (cfgLoad)   modeIb <= 1'b0;
    else if (modeSet)   modeIb <= modeIbIn;
  end

  always_comb begin
    strb            = '0;
    strb.cfgLoad    = cfgLoad;
    strb.ibBaseLoad = ibBaseLoad;
    if (!cfgLoad) begin
      strb.ringRp    = modeIb ? RP_HOLD : activeOp;
      strb.ibRp      = modeIb ? activeOp : RP_HOLD;
      strb.ringWpSet = !modeIb && wptrSet;
      strb.ibWpSet   = modeIb && wptrSet;
      strb.ringWpDb  = dbValid && !(!modeIb && wptrSet);
    end
  end

  // R7: the inactive pair receives no operation
  p_inactive_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !modeIb |-> (strb.ibRp == RP_HOLD && !strb.ibWpSet));

  // R12: a mode change lands one cycle later
  p_mode_switch_r12: assert property (@(posedge clk) disable iff (!rstN)
    (modeSet && !cfgLoad) |=> (modeIb == $past(modeIbIn)));

  // R2: mapping returns the queue to ring mode
  p_map_ring_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !modeIb);

  // R8: a jump request is never downgraded on the active pair
  p_ffwd_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ffwd && !cfgLoad) |-> (modeIb ? strb.ibRp == RP_FFWD : strb.ringRp == RP_FFWD));

endmodule

// File: rtl/cmdq_dpath.sv
module cmdq_dpath
  import cmdq_pkg::*;
#(
  parameter int PTR_W  = 64,
  parameter int LOG_W  = 6,
  parameter int CNT_W  = 14,
  parameter int QSEL_W = 2,
  parameter int ENG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              modeIb,
  input  logic [LOG_W-1:0]  cfgRingLog,
  input  logic [PTR_W-1:0]  cfgRingBase,
  input  logic [PTR_W-1:0]  cfgInitRptr,
  input  logic [QSEL_W-1:0] cfgQueueSel,
  input  logic [ENG_W-1:0]  cfgEngine,
  input  logic [PTR_W-1:0]  ibBaseIn,
  input  logic [CNT_W-1:0]  advDwords,
  input  logic [PTR_W-1:0]  rptrVal,
  input  logic [PTR_W-1:0]  wptrVal,
  input  logic [PTR_W-1:0]  dbWptr,
  output logic [PTR_W-1:0]  fetchAddr,
  output logic [PTR_W-1:0]  wrAddr,
  output logic              empty,
  output logic              privileged,
  output logic [ENG_W:0]    engineNum
);

  localparam int ENG_OUT_W = ENG_W + 1;

  logic [PTR_W-1:0] ringBase, ibBase;
  logic [PTR_W-1:0] ringRptr, ringWptr, ibRptr, ibWptr;
  logic [LOG_W-1:0] ringLog;
  logic [PTR_W-1:0] ringMask;
  logic [PTR_W-1:0] advBytes;

  assign advBytes = PTR_W'({advDwords, 2'b00});

  cmdq_size_mask #(.PTR_W(PTR_W), .LOG_W(LOG_W)) u_mask (
    .logField(ringLog),
    .mask    (ringMask)
  );

  // Mapping state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringBase   <= '0;
      ringLog    <= '0;
      privileged <= 1'b0;
      engineNum  <= '0;
    end else if (strb.cfgLoad) begin
      ringBase   <= cfgRingBase;
      ringLog    <= cfgRingLog;
      privileged <= (cfgQueueSel == '0);
      engineNum  <= ENG_OUT_W'(cfgEngine) + ENG_OUT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                ibBase <= '0;
    else if (strb.ibBaseLoad) ibBase <= ibBaseIn;
  end

  // Ring pointer pair
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringRptr <= '0;
      ringWptr <= '0;
    end else if (strb.cfgLoad) begin
      ringRptr <= cfgInitRptr;
      ringWptr <= cfgInitRptr;
    end else begin
      case (strb.ringRp)
        RP_ADV:  ringRptr <= ringRptr + advBytes;
        RP_SET:  ringRptr <= rptrVal;
        RP_FFWD: ringRptr <= ringWptr;
        default: ;
      endcase
      if (strb.ringWpSet)     ringWptr <= wptrVal;
      else if (strb.ringWpDb) ringWptr <= dbWptr;
    end
  end

  // Indirect pointer pair
  always_ff @(posedge clk) begin
    if (!rstN || strb.cfgLoad) begin
      ibRptr <= '0;
      ibWptr <= '0;
    end else begin
      case (strb.ibRp)
        RP_ADV:  ibRptr <= ibRptr + advBytes;
        RP_SET:  ibRptr <= rptrVal;
        RP_FFWD: ibRptr <= ibWptr;
        default: ;
      endcase
      if (strb.ibWpSet) ibWptr <= wptrVal;
    end
  end

  // Address formation
  always_comb begin
    if (modeIb) begin
      fetchAddr = ibBase + ibRptr;
      wrAddr    = ibBase + ibWptr;
      empty     = (ibRptr == ibWptr);
    end else begin
      fetchAddr = ringBase + (ringRptr & ringMask);
      wrAddr    = ringBase + (ringWptr & ringMask);
      empty     = (ringRptr == ringWptr);
    end
  end

  // R6: advance moves the ring read pointer by four bytes per dword
  p_ring_adv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ringRp == RP_ADV) |=> (ringRptr == $past(ringRptr) + PTR_W'({$past(advDwords), 2'b00})));

  // R8: ring jump lands on the pre-edge write pointer
  p_ring_ffwd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ringRp == RP_FFWD) |=> (ringRptr == $past(ringWptr)));

  // R2: mapping leaves both pairs balanced
  p_map_init_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgLoad |=> (ringRptr == ringWptr && ibRptr == '0 && ibWptr == '0));

  // R9: a doorbell reaches the ring write pointer
  p_doorbell_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.ringWpDb |=> (ringWptr == $past(dbWptr)));

  // R10: an indirect jump without a write leaves the queue empty
  p_ib_ffwd_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ibRp == RP_FFWD && !strb.ibWpSet && modeIb) |=> (empty || !modeIb));

endmodule

// File: rtl/cmdq_ptr_tracker.sv
module cmdq_ptr_tracker
  import cmdq_pkg::*;
#(
  parameter int PTR_W  = 64,
  parameter int LOG_W  = 6,
  parameter int CNT_W  = 14,
  parameter int QSEL_W = 2,
  parameter int ENG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [LOG_W-1:0]  cfgRingLog,
  input  logic [PTR_W-1:0]  cfgRingBase,
  input  logic [PTR_W-1:0]  cfgInitRptr,
  input  logic [QSEL_W-1:0] cfgQueueSel,
  input  logic [ENG_W-1:0]  cfgEngine,
  input  logic              ibBaseLoad,
  input  logic [PTR_W-1:0]  ibBaseIn,
  input  logic              modeSet,
  input  logic              modeIbIn,
  input  logic              advValid,
  input  logic [CNT_W-1:0]  advDwords,
  input  logic              rptrSet,
  input  logic [PTR_W-1:0]  rptrVal,
  input  logic              wptrSet,
  input  logic [PTR_W-1:0]  wptrVal,
  input  logic              dbValid,
  input  logic [PTR_W-1:0]  dbWptr,
  input  logic              ffwd,
  output logic [PTR_W-1:0]  fetchAddr,
  output logic [PTR_W-1:0]  wrAddr,
  output logic              empty,
  output logic              ibMode,
  output logic              privileged,
  output logic [ENG_W:0]    engineNum
);

  strobe_t strb;
  logic    modeIb;

  cmdq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgLoad   (cfgLoad),
    .ibBaseLoad(ibBaseLoad),
    .modeSet   (modeSet),
    .modeIbIn  (modeIbIn),
    .advValid  (advValid),
    .rptrSet   (rptrSet),
    .wptrSet   (wptrSet),
    .dbValid   (dbValid),
    .ffwd      (ffwd),
    .strb      (strb),
    .modeIb    (modeIb)
  );

  cmdq_dpath #(
    .PTR_W(PTR_W), .LOG_W(LOG_W), .CNT_W(CNT_W), .QSEL_W(QSEL_W), .ENG_W(ENG_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .modeIb     (modeIb),
    .cfgRingLog (cfgRingLog),
    .cfgRingBase(cfgRingBase),
    .cfgInitRptr(cfgInitRptr),
    .cfgQueueSel(cfgQueueSel),
    .cfgEngine  (cfgEngine),
    .ibBaseIn   (ibBaseIn),
    .advDwords  (advDwords),
    .rptrVal    (rptrVal),
    .wptrVal    (wptrVal),
    .dbWptr     (dbWptr),
    .fetchAddr  (fetchAddr),
    .wrAddr     (wrAddr),
    .empty      (empty),
    .privileged (privileged),
    .engineNum  (engineNum)
  );

  assign ibMode = modeIb;

endmodule

// File: tb/cmdq_ptr_tracker_test.sv
`timescale 1ns/1ps
module cmdq_ptr_tracker_test;
  localparam int PW = 16;
  localparam int LW = 6;
  localparam int CW = 14;
  localparam int QW = 2;
  localparam int EW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 0, ibBaseLoad = 0, modeSet = 0, modeIbIn = 0;
  logic advValid = 0, rptrSet = 0, wptrSet = 0, dbValid = 0, ffwd = 0;
  logic [LW-1:0] cfgRingLog = '0;
  logic [PW-1:0] cfgRingBase = '0, cfgInitRptr = '0, ibBaseIn = '0;
  logic [PW-1:0] rptrVal = '0, wptrVal = '0, dbWptr = '0;
  logic [QW-1:0] cfgQueueSel = '0;
  logic [EW-1:0] cfgEngine = '0;
  logic [CW-1:0] advDwords = '0;
  logic [PW-1:0] fetchAddr, wrAddr;
  logic empty, ibMode, privileged;
  logic [EW:0] engineNum;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state
  logic [PW-1:0] mRB, mIB, mRR, mRW, mIR, mIW;
  logic [LW-1:0] mLog;
  logic mMode, mPriv;
  logic [EW:0] mEng;

  always #2.5 clk = ~clk;

  cmdq_ptr_tracker #(.PTR_W(PW), .LOG_W(LW), .CNT_W(CW), .QSEL_W(QW), .ENG_W(EW)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgRingLog(cfgRingLog),
    .cfgRingBase(cfgRingBase), .cfgInitRptr(cfgInitRptr), .cfgQueueSel(cfgQueueSel),
    .cfgEngine(cfgEngine), .ibBaseLoad(ibBaseLoad), .ibBaseIn(ibBaseIn),
    .modeSet(modeSet), .modeIbIn(modeIbIn), .advValid(advValid), .advDwords(advDwords),
    .rptrSet(rptrSet), .rptrVal(rptrVal), .wptrSet(wptrSet), .wptrVal(wptrVal),
    .dbValid(dbValid), .dbWptr(dbWptr), .ffwd(ffwd), .fetchAddr(fetchAddr),
    .wrAddr(wrAddr), .empty(empty), .ibMode(ibMode), .privileged(privileged),
    .engineNum(engineNum)
  );

  function automatic logic [PW-1:0] sizeMask(input logic [LW-1:0] lg);
    int e = int'(lg) + 3;
    if (e >= PW) return '1;
    return PW'((32'd1 << e) - 1);
  endfunction

  function automatic logic [PW-1:0] expFetch();
    return mMode ? PW'(mIB + mIR) : PW'(mRB + (mRR & sizeMask(mLog)));
  endfunction

  function automatic logic [PW-1:0] expWr();
    return mMode ? PW'(mIB + mIW) : PW'(mRB + (mRW & sizeMask(mLog)));
  endfunction

  function automatic logic expEmpty();
    return mMode ? (mIR == mIW) : (mRR == mRW);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    chk(mMode ? "R5" : "R3", "fetchAddr", 32'(fetchAddr), 32'(expFetch()));
    chk(mMode ? "R5" : "R4", "wrAddr", 32'(wrAddr), 32'(expWr()));
    chk("R10", "empty", 32'(empty), 32'(expEmpty()));
    chk("R12", "ibMode", 32'(ibMode), 32'(mMode));
    chk("R11", "privileged", 32'(privileged), 32'(mPriv));
    chk("R11", "engineNum", 32'(engineNum), 32'(mEng));
  endtask

  task automatic modelStep();
    logic [PW-1:0] adv = PW'({advDwords, 2'b00});
    logic [PW-1:0] oldRW = mRW, oldIW = mIW;
    if (ibBaseLoad) mIB = ibBaseIn;
    if (cfgLoad) begin
      mRB = cfgRingBase; mLog = cfgRingLog;
      mRR = cfgInitRptr; mRW = cfgInitRptr; mIR = '0; mIW = '0;
      mMode = 1'b0; mPriv = (cfgQueueSel == '0);
      mEng = (EW+1)'(cfgEngine) + (EW+1)'(1);
    end else begin
      if (!mMode) begin
        if (ffwd) mRR = oldRW; else if (rptrSet) mRR = rptrVal; else if (advValid) mRR = PW'(mRR + adv);
        if (wptrSet) mRW = wptrVal; else if (dbValid) mRW = dbWptr;
      end else begin
        if (ffwd) mIR = oldIW; else if (rptrSet) mIR = rptrVal; else if (advValid) mIR = PW'(mIR + adv);
        if (wptrSet) mIW = wptrVal;
        if (dbValid) mRW = dbWptr;
      end
      if (modeSet) mMode = modeIbIn;
    end
  endtask

  task automatic clearIn();
    cfgLoad = 0; ibBaseLoad = 0; modeSet = 0; advValid = 0;
    rptrSet = 0; wptrSet = 0; dbValid = 0; ffwd = 0;
  endtask

  // Inputs are set at the falling edge; one rising edge; compare at next fall.
  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkAll();
    clearIn();
  endtask

  initial begin
    mRB = '0; mIB = '0; mRR = '0; mRW = '0; mIR = '0; mIW = '0;
    mLog = '0; mMode = 0; mPriv = 0; mEng = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "fetchAddr", 32'(fetchAddr), 0);
    chk("R1", "wrAddr", 32'(wrAddr), 0);
    chk("R1", "empty", 32'(empty), 1);
    chk("R1", "ibMode", 32'(ibMode), 0);
    chk("R1", "privileged", 32'(privileged), 0);
    chk("R1", "engineNum", 32'(engineNum), 0);

    // R2 / R11: map a 32-byte ring; stray ops in the same cycle are overridden
    cfgLoad = 1; cfgRingLog = 6'd2; cfgRingBase = 16'h1000; cfgInitRptr = 16'h0010;
    cfgQueueSel = 2'd0; cfgEngine = 2'd3; advValid = 1; advDwords = 14'd5; modeSet = 1; modeIbIn = 1;
    cycle();
    chk("R2", "fetchAddr", 32'(fetchAddr), 32'h1010);
    chk("R2", "empty", 32'(empty), 1);
    chk("R11", "engineNum", 32'(engineNum), 4);
    chk("R11", "privileged", 32'(privileged), 1);

    // R3 / R6: advance 10 dwords, pointer runs past the 32-byte ring
    advValid = 1; advDwords = 14'd10;
    cycle();
    chk("R3", "fetchAddr wrapped", 32'(fetchAddr), 32'h1018);
    // R7 / R10: write pointer at the masked twin of the read pointer is not empty
    wptrSet = 1; wptrVal = 16'h0018;
    cycle();
    chk("R10", "empty unmasked compare", 32'(empty), 0);
    chk("R4", "wrAddr", 32'(wrAddr), 32'h1018);

    // R8: jump beats set and advance in the same cycle
    ffwd = 1; rptrSet = 1; rptrVal = 16'h0777; advValid = 1; advDwords = 14'd3;
    cycle();
    chk("R8", "empty after jump", 32'(empty), 1);

    // R12 / R5: switch to indirect with a base; no modulo there
    ibBaseLoad = 1; ibBaseIn = 16'h4000; modeSet = 1; modeIbIn = 1;
    cycle();
    rptrSet = 1; rptrVal = 16'h0100; wptrSet = 1; wptrVal = 16'h0180;
    cycle();
    chk("R5", "fetchAddr no wrap", 32'(fetchAddr), 32'h4100);
    chk("R5", "wrAddr no wrap", 32'(wrAddr), 32'h4180);

    // R9: doorbell in indirect mode touches only the ring write pointer
    dbValid = 1; dbWptr = 16'h0024;
    cycle();
    chk("R9", "ib wrAddr unchanged", 32'(wrAddr), 32'h4180);
    modeSet = 1; modeIbIn = 0;
    cycle();
    chk("R9", "ring wrAddr from doorbell", 32'(wrAddr), 32'h1004);
    // R9: in ring mode wptrSet wins over doorbell
    wptrSet = 1; wptrVal = 16'h0008; dbValid = 1; dbWptr = 16'h0030;
    cycle();
    chk("R9", "set over doorbell", 32'(wrAddr), 32'h1008);
    // R12: indirect pair kept its values across the switch
    modeSet = 1; modeIbIn = 1;
    cycle();
    chk("R12", "ib pair retained", 32'(fetchAddr), 32'h4100);

    // R3: size field 13 reaches 2^16 bytes, so no modulo applies
    cfgLoad = 1; cfgRingLog = 6'd13; cfgRingBase = 16'h2000; cfgInitRptr = 16'hF000;
    cfgQueueSel = 2'd2; cfgEngine = 2'd0;
    cycle();
    chk("R3", "saturated size", 32'(fetchAddr), 32'h1000);
    chk("R11", "not privileged", 32'(privileged), 0);
    // R6: advance in ring leaves the indirect pair alone
    advValid = 1; advDwords = 14'h3FFF;
    cycle();

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      cfgLoad    = ($urandom % 64) == 0;
      cfgRingLog = LW'($urandom % 20);
      if (($urandom % 16) == 0) cfgRingLog = 6'd63;
      cfgRingBase = PW'($urandom); cfgInitRptr = PW'($urandom);
      cfgQueueSel = QW'($urandom); cfgEngine = EW'($urandom);
      ibBaseLoad = ($urandom % 16) == 0; ibBaseIn = PW'($urandom);
      modeSet = ($urandom % 8) == 0; modeIbIn = 1'($urandom);
      advValid = ($urandom % 2) == 0;
      advDwords = (($urandom % 8) == 0) ? 14'h3FFF : CW'($urandom % 64);
      rptrSet = ($urandom % 8) == 0; rptrVal = PW'($urandom);
      wptrSet = ($urandom % 6) == 0; wptrVal = PW'($urandom);
      dbValid = ($urandom % 4) == 0; dbWptr = PW'($urandom);
      ffwd = ($urandom % 10) == 0;
      cycle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule